// File: doc/BRIEF.md
# Bus-Master DMA Channel Command and Status Registers

This block holds the software-visible command and status registers of one channel of a bus-master, disk-style DMA engine. Software reaches them through a byte-wide register port. A start bit in the command byte launches the engine. The status byte reports whether the engine is running, whether a bus fault hit a transfer, whether the attached device raised its interrupt, and two capability flags that software owns.

The DMA engine takes its run-enable from the active flag. Finishing the descriptor marked as the last one drops the active flag, and so does writing the start bit to 0. The error and interrupt flags stay set until software writes a 1 to them. Reads are combinational from the current address. Writes take effect on the clock edge at which the write strobe is high.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset both the command byte (offset 0) and the status byte (offset 2) read 0x00, and runEnable and irqReq are 0.
- R2: Status bit 7 and status bits 4:3 always read 0, and writes to them are ignored. Offsets 1 and 3 read 0x00, and writes to them change nothing.
- R3: Status bits 6 and 5 are read/write flags with no effect on runEnable or irqReq.
- R4: A cycle with devIrq high sets status bit 2. irqReq is 1 exactly while status bit 2 is 1.
- R5: Writing 1 to status bit 2 or status bit 1 clears that bit. Writing 0 to either bit leaves it unchanged.
- R6: A cycle in which any bit of busFault is high sets status bit 1. The busFault bits are bit 0 for master abort, bit 1 for target abort and bit 2 for parity error.
- R7: Writing the command byte with bit 0 = 1 sets status bit 0 (active) on that edge, and runEnable equals active. Writes to status bit 0 are ignored. The command byte reads back bit 0 as the stored start bit and all other bits as 0.
- R8: A cycle with eotDone high clears active, unless a command write occurs in the same cycle. The stored start bit stays 1.
- R9: Writing the command byte with bit 0 = 0 clears active and the start bit.
- R10: When a hardware set event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | 2 | Register byte offset |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr, combinational |
| devIrq | input | 1 | Device interrupt line |
| eotDone | input | 1 | Pulse: last-descriptor transfer complete |
| busFault | input | 3 | Fault pulses: [0] master abort, [1] target abort, [2] parity error |
| runEnable | output | 1 | Run permission to the DMA engine |
| irqReq | output | 1 | Interrupt request |

## Verification
The assertions assume that every input is synchronous to clk and settles between edges. They also assume that a register write is a single-cycle strobe whose address and data are valid in the same cycle. The bench drives every input on the falling edge and holds each strobe or pulse for exactly one rising edge. It samples read data and outputs on the following falling edge. Same-cycle collisions, such as a set event together with a clear, or an end-of-table pulse next to a command write, are placed deliberately on one edge. This lets the priority rules be observed.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  // Decoded register-write intents passed from control to datapath
  typedef struct packed {
    logic       cmdWr;    // command byte written this cycle
    logic       statWr;   // status byte written this cycle
    logic       startVal; // new start bit value
    logic       clrInt;   // write-one to interrupt flag
    logic       clrErr;   // write-one to error flag
    logic [1:0] capVal;   // new capability flags {drive1, drive0}
  } regStrobes_t;
endpackage

// File: rtl/dma_regs_ctrl.sv
module dma_regs_ctrl
  import dma_regs_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int CMD_OFS  = 0,
  parameter int STAT_OFS = 2
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  input  logic [7:0]        cmdByte,
  input  logic [7:0]        statByte,
  output regStrobes_t       strobes,
  output logic [7:0]        regRdData
);
  localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(CMD_OFS);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

  logic hitCmd, hitStat;
  assign hitCmd  = (regAddr == CMD_A);
  assign hitStat = (regAddr == STAT_A);

  always_comb begin
    strobes.cmdWr    = regWrEn && hitCmd;
    strobes.statWr   = regWrEn && hitStat;
    strobes.startVal = regWrData[0];
    strobes.clrInt   = regWrEn && hitStat && regWrData[2];
    strobes.clrErr   = regWrEn && hitStat && regWrData[1];
    strobes.capVal   = regWrData[6:5];
  end

  always_comb begin
    if (hitCmd)       regRdData = cmdByte;
    else if (hitStat) regRdData = statByte;
    else              regRdData = 8'h00;
  end

  // R2: reserved and simplex bits of the status byte never read as 1
  always_comb begin
    if (hitStat) assert_rsvd_zero_R2: assert (regRdData[7] == 1'b0 && regRdData[4:3] == 2'b00);
  end
endmodule

// File: rtl/dma_regs_dp.sv
module dma_regs_dp
  import dma_regs_pkg::*;
#(
  parameter int NUM_FAULT = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobes_t          strobes,
  input  logic                 devIrq,
  input  logic                 eotDone,
  input  logic [NUM_FAULT-1:0] busFault,
  output logic [7:0]           cmdByte,
  output logic [7:0]           statByte,
  output logic                 runEnable,
  output logic                 irqReq
);
  logic       startBit, activeFlag, errFlag, intFlag;
  logic [1:0] capBits;
  logic       anyFault;

  assign anyFault = |busFault;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startBit   <= 1'b0;
      activeFlag <= 1'b0;
      errFlag    <= 1'b0;
      intFlag    <= 1'b0;
      capBits    <= 2'b00;
    end else begin
      if (strobes.cmdWr) begin
        startBit   <= strobes.startVal;
        activeFlag <= strobes.startVal;
      end else if (eotDone) begin
        activeFlag <= 1'b0;
      end
      if (strobes.statWr) capBits <= strobes.capVal;
      // hardware set takes priority over software clear
      if (devIrq)              intFlag <= 1'b1;
      else if (strobes.clrInt) intFlag <= 1'b0;
      if (anyFault)            errFlag <= 1'b1;
      else if (strobes.clrErr) errFlag <= 1'b0;
    end
  end

  assign cmdByte   = {7'b0, startBit};
  assign statByte  = {1'b0, capBits, 2'b00, intFlag, errFlag, activeFlag};
  assign runEnable = activeFlag;
  assign irqReq    = intFlag;

  assert_start_sets_active_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cmdWr && strobes.startVal |=> runEnable);
  assert_stop_clears_active_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cmdWr && !strobes.startVal |=> !runEnable && !cmdByte[0]);
  assert_eot_clears_active_R8: assert property (@(posedge clk) disable iff (!rstN)
    eotDone && !strobes.cmdWr |=> !runEnable && $stable(cmdByte));
  assert_irq_sets_R4: assert property (@(posedge clk) disable iff (!rstN)
    devIrq |=> irqReq && statByte[2]);
  assert_fault_sets_err_R6: assert property (@(posedge clk) disable iff (!rstN)
    anyFault |=> statByte[1]);
  assert_w1c_int_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrInt && !devIrq |=> !statByte[2]);
  assert_cap_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.statWr |=> statByte[6:5] == $past(strobes.capVal));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int CMD_OFS   = 0,
  parameter int STAT_OFS  = 2,
  parameter int NUM_FAULT = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [7:0]           regWrData,
  output logic [7:0]           regRdData,
  input  logic                 devIrq,
  input  logic                 eotDone,
  input  logic [NUM_FAULT-1:0] busFault,
  output logic                 runEnable,
  output logic                 irqReq
);
  regStrobes_t strobes;
  logic [7:0]  cmdByte, statByte;

  dma_regs_ctrl #(.ADDR_W(ADDR_W), .CMD_OFS(CMD_OFS), .STAT_OFS(STAT_OFS)) ctrl_i (
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .cmdByte(cmdByte), .statByte(statByte), .strobes(strobes), .regRdData(regRdData));

  dma_regs_dp #(.NUM_FAULT(NUM_FAULT)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .devIrq(devIrq), .eotDone(eotDone),
    .busFault(busFault), .cmdByte(cmdByte), .statByte(statByte),
    .runEnable(runEnable), .irqReq(irqReq));
endmodule

// File: tb/dma_chan_regs_tb.sv
`timescale 1ns/1ps
module dma_chan_regs_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       devIrq = 1'b0, eotDone = 1'b0;
  logic [2:0] busFault = 3'b000;
  logic       runEnable, irqReq;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  dma_chan_regs dut_i (.clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .devIrq(devIrq), .eotDone(eotDone),
    .busFault(busFault), .runEnable(runEnable), .irqReq(irqReq));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  // one edge with the given stimulus, then inputs return idle at the falling edge
  task automatic step(input logic we, input logic [1:0] a, input logic [7:0] d,
                      input logic irq, input logic eot, input logic [2:0] flt);
    @(negedge clk);
    regWrEn = we; regAddr = a; regWrData = d; devIrq = irq; eotDone = eot; busFault = flt;
    @(negedge clk);
    regWrEn = 1'b0; devIrq = 1'b0; eotDone = 1'b0; busFault = 3'b000;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    step(1'b1, a, d, 1'b0, 1'b0, 3'b000);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    regAddr = a; #0.5; d = regRdData;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(2'd0, v); chk("R1 cmd", v, 8'h00);
    rd(2'd2, v); chk("R1 stat", v, 8'h00);
    chk("R1 runEnable", {7'b0, runEnable}, 8'h00);
    chk("R1 irqReq", {7'b0, irqReq}, 8'h00);
  endtask

  task automatic t_reserved;
    logic [7:0] v;
    wr(2'd2, 8'hFF);
    rd(2'd2, v); chk("R2 R3 stat after 0xFF", v, 8'h60);
    chk("R3 runEnable unaffected", {7'b0, runEnable}, 8'h00);
    chk("R3 irqReq unaffected", {7'b0, irqReq}, 8'h00);
    wr(2'd1, 8'hFF); wr(2'd3, 8'hFF);
    rd(2'd1, v); chk("R2 offset1", v, 8'h00);
    rd(2'd3, v); chk("R2 offset3", v, 8'h00);
    rd(2'd0, v); chk("R2 cmd untouched", v, 8'h00);
    rd(2'd2, v); chk("R2 stat untouched", v, 8'h60);
    wr(2'd2, 8'h20);
    rd(2'd2, v); chk("R3 drive0 only", v, 8'h20);
    wr(2'd2, 8'h00);
    rd(2'd2, v); chk("R3 cleared", v, 8'h00);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    step(1'b0, 2'd2, 8'h00, 1'b1, 1'b0, 3'b000);
    rd(2'd2, v); chk("R4 int set", v, 8'h04);
    chk("R4 irqReq", {7'b0, irqReq}, 8'h01);
    wr(2'd2, 8'h00);
    rd(2'd2, v); chk("R5 write 0 keeps int", v, 8'h04);
    wr(2'd2, 8'h04);
    rd(2'd2, v); chk("R5 w1c int", v, 8'h00);
    chk("R4 irqReq low", {7'b0, irqReq}, 8'h00);
  endtask

  task automatic t_faults;
    logic [7:0] v;
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 2'd2, 8'h00, 1'b0, 1'b0, 3'(1 << i));
      rd(2'd2, v); chk($sformatf("R6 fault bit %0d", i), v, 8'h02);
      wr(2'd2, 8'h00);
      rd(2'd2, v); chk("R5 write 0 keeps err", v, 8'h02);
      wr(2'd2, 8'h02);
      rd(2'd2, v); chk("R5 w1c err", v, 8'h00);
    end
  endtask

  task automatic t_collide;
    logic [7:0] v;
    step(1'b0, 2'd2, 8'h00, 1'b1, 1'b0, 3'b100);
    step(1'b1, 2'd2, 8'h06, 1'b1, 1'b0, 3'b010);
    rd(2'd2, v); chk("R10 set wins", v, 8'h06);
    wr(2'd2, 8'h06);
    rd(2'd2, v); chk("R10 cleared after", v, 8'h00);
  endtask

  task automatic t_run;
    logic [7:0] v;
    wr(2'd0, 8'h01);
    rd(2'd2, v); chk("R7 active set", v, 8'h01);
    chk("R7 runEnable", {7'b0, runEnable}, 8'h01);
    rd(2'd0, v); chk("R7 cmd readback", v, 8'h01);
    wr(2'd2, 8'h00);
    rd(2'd2, v); chk("R7 status write ignores active", v, 8'h01);
    step(1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 3'b000);
    rd(2'd2, v); chk("R8 eot clears active", v, 8'h00);
    chk("R8 runEnable low", {7'b0, runEnable}, 8'h00);
    rd(2'd0, v); chk("R8 start bit kept", v, 8'h01);
    step(1'b1, 2'd0, 8'h01, 1'b0, 1'b1, 3'b000);
    rd(2'd2, v); chk("R8 cmd write beats eot", v, 8'h01);
    wr(2'd0, 8'hFE);
    rd(2'd2, v); chk("R9 stop clears active", v, 8'h00);
    rd(2'd0, v); chk("R9 start bit cleared", v, 8'h00);
    chk("R9 runEnable low", {7'b0, runEnable}, 8'h00);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_reserved();
    t_irq();
    t_faults();
    t_collide();
    t_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule